// File: doc/BRIEF.md
# Accumulator Arithmetic and Status Unit

This unit holds the accumulator and the 8-bit status byte of a small accumulator processor and updates them one opcode at a time. Each cycle in which the apply strobe is high, the opcode byte is decoded from fixed bit fields. The unit then does one of four things: an arithmetic or logic operation between the accumulator and the operand byte, a single-bit status set or clear, or a one-place left shift of either the accumulator or a memory byte.

The sequencer around the unit supplies the opcode and the operand, and it pulses the strobe at the moment the operation should take effect. The result of a memory shift is held on a separate output, so the sequencer can write it back to memory. Opcodes the unit does not recognise leave every register untouched.

Top module: `acc_flag_alu`

## Requirements
- R1: While rst_n is low, and directly after it rises, acc_o, mem_o and stat_o are all 0x00.
- R2: A cycle with apply_i low changes none of acc_o, mem_o or stat_o.
- R3: With op_i[1:0]=01, the field op_i[7:5] selects 0 OR, 1 AND, 2 XOR or 5 load. The accumulator takes the result, N (bit 7) copies result bit 7, and Z (bit 1) is 1 exactly when the result is zero. C (bit 0) and V (bit 6) keep their values.
- R4: With op_i[1:0]=01 and op_i[7:5]=3, the accumulator takes the low byte of A+B+C. C becomes bit 8 of that sum, V becomes bit 7 of (res^A)&(res^B), and N and Z follow the result.
- R5: With op_i[1:0]=01 and op_i[7:5]=7, the accumulator takes the low byte of A+~B+C. C, V, N and Z follow the same rules as R4, with B being the raw operand in the V term.
- R6: With op_i[1:0]=01 and op_i[7:5]=6, the unit forms A+~B with no carry-in. It sets C from bit 8 and N and Z from the low byte. The accumulator and V are left unchanged.
- R7: With op_i[1:0]=00 and op_i[4:2]=110, the field op_i[7:5] selects 0 clear C, 1 set C, 2 clear I (bit 2), 3 set I, 5 clear V, 6 clear D (bit 3) or 7 set D. The value 4 has no effect. The accumulator and the memory byte are not touched.
- R8: Opcode fields op_i[1:0]=10, op_i[7:5]=000 and op_i[3:0]=0xA shift the accumulator left by one place. C takes the old bit 7, a zero enters at bit 0, N and Z follow the result, and mem_o is unchanged.
- R9: With op_i[1:0]=10, op_i[7:5]=000 and op_i[3:0] other than 0xA, mem_o takes the operand shifted left by one place. C takes operand bit 7, N and Z follow the shifted byte, and the accumulator is unchanged.
- R10: Any other opcode leaves acc_o, mem_o and stat_o unchanged. This includes op_i[1:0]=01 with op_i[7:5]=4, any other op_i[1:0]=10 opcode, and op_i[1:0]=11.
- R11: Bits 5 and 4 of stat_o never change. Bits 3 and 2 change only through the R7 operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 8 | Opcode byte to decode |
| operand_i | input | W | Operand byte B, or the memory byte to shift |
| apply_i | input | 1 | Strobe: apply the decoded operation at this edge |
| acc_o | output | W | Accumulator |
| mem_o | output | W | Last shifted memory byte |
| stat_o | output | 8 | Status byte: C0 Z1 I2 D3 V6 N7 |

## Verification
Every register drives an output directly, so a wrong next-state value shows up one cycle after the strobe that caused it. A wrong carry or overflow then also corrupts the next add or subtract, which reads C as an input. A decode slip, where a compare or a rejected opcode writes A or where a flag operation hits the wrong bit, shows up as a changed accumulator or status bit at that same edge. The checks therefore compare the full accumulator, status and memory bytes after every single strobe, so an error is reported at the cycle it is made and is not hidden by later operations.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OP_W   = 8;
    localparam int STAT_W = 8;

    // status bit positions
    localparam int BIT_C = 0;
    localparam int BIT_Z = 1;
    localparam int BIT_I = 2;
    localparam int BIT_D = 3;
    localparam int BIT_V = 6;
    localparam int BIT_N = 7;

    typedef enum logic [2:0] {
        CLS_IDLE,
        CLS_ARITH,
        CLS_FLAG,
        CLS_SHL_ACC,
        CLS_SHL_MEM
    } op_cls_e;

    typedef enum logic [2:0] {
        FN_OR  = 3'd0,
        FN_AND = 3'd1,
        FN_XOR = 3'd2,
        FN_ADC = 3'd3,
        FN_STO = 3'd4,
        FN_LD  = 3'd5,
        FN_CMP = 3'd6,
        FN_SBC = 3'd7
    } arith_fn_e;

    typedef struct packed {
        logic wr_acc;
        logic upd_nz;
        logic upd_c;
        logic upd_v;
    } arith_ctl_t;

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
    import acc_alu_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output op_cls_e         cls_o,
    output logic [2:0]      fn_o
);

    localparam logic [1:0] GRP_ARITH = 2'b01;
    localparam logic [1:0] GRP_FLAG  = 2'b00;
    localparam logic [1:0] GRP_SHIFT = 2'b10;
    localparam logic [2:0] FLAG_MID  = 3'b110;
    localparam logic [2:0] NO_OP_FN  = 3'd4;
    localparam logic [3:0] ACC_NIB   = 4'hA;

    logic [1:0] grp;
    logic [2:0] hi;

    assign grp  = op_i[1:0];
    assign hi   = op_i[7:5];
    assign fn_o = hi;

    always_comb begin
        cls_o = CLS_IDLE;
        case (grp)
            GRP_ARITH: begin
                if (hi != NO_OP_FN) cls_o = CLS_ARITH;
            end
            GRP_FLAG: begin
                if (op_i[4:2] == FLAG_MID && hi != NO_OP_FN) cls_o = CLS_FLAG;
            end
            GRP_SHIFT: begin
                if (hi == 3'd0) begin
                    cls_o = (op_i[3:0] == ACC_NIB) ? CLS_SHL_ACC : CLS_SHL_MEM;
                end
            end
            default: cls_o = CLS_IDLE;
        endcase
    end

endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         c_i,
    input  logic [2:0]   fn_i,
    output logic [W-1:0] res_o,
    output logic         c_o,
    output logic         v_o,
    output arith_ctl_t   ctl_o
);

    localparam int SW = W + 1;

    logic [SW-1:0] a_ext;
    logic [SW-1:0] b_ext;
    logic [SW-1:0] nb_ext;
    logic [SW-1:0] cin_ext;
    logic [SW-1:0] sum;
    logic [W-1:0]  sgn_mix;

    assign a_ext   = {1'b0, a_i};
    assign b_ext   = {1'b0, b_i};
    assign nb_ext  = {1'b0, ~b_i};
    assign cin_ext = {{W{1'b0}}, c_i};

    always_comb begin
        sum   = '0;
        res_o = a_i;
        ctl_o = '0;
        case (arith_fn_e'(fn_i))
            FN_OR: begin
                res_o = a_i | b_i;
                ctl_o = '{wr_acc: 1'b1, upd_nz: 1'b1, upd_c: 1'b0, upd_v: 1'b0};
            end
            FN_AND: begin
                res_o = a_i & b_i;
                ctl_o = '{wr_acc: 1'b1, upd_nz: 1'b1, upd_c: 1'b0, upd_v: 1'b0};
            end
            FN_XOR: begin
                res_o = a_i ^ b_i;
                ctl_o = '{wr_acc: 1'b1, upd_nz: 1'b1, upd_c: 1'b0, upd_v: 1'b0};
            end
            FN_LD: begin
                res_o = b_i;
                ctl_o = '{wr_acc: 1'b1, upd_nz: 1'b1, upd_c: 1'b0, upd_v: 1'b0};
            end
            FN_ADC: begin
                sum   = a_ext + b_ext + cin_ext;
                res_o = sum[W-1:0];
                ctl_o = '{wr_acc: 1'b1, upd_nz: 1'b1, upd_c: 1'b1, upd_v: 1'b1};
            end
            FN_SBC: begin
                sum   = a_ext + nb_ext + cin_ext;
                res_o = sum[W-1:0];
                ctl_o = '{wr_acc: 1'b1, upd_nz: 1'b1, upd_c: 1'b1, upd_v: 1'b1};
            end
            FN_CMP: begin
                sum   = a_ext + nb_ext;
                res_o = sum[W-1:0];
                ctl_o = '{wr_acc: 1'b0, upd_nz: 1'b1, upd_c: 1'b1, upd_v: 1'b0};
            end
            default: begin
                res_o = a_i;
                ctl_o = '0;
            end
        endcase
    end

    assign sgn_mix = (res_o ^ a_i) & (res_o ^ b_i);
    assign c_o     = sum[W];
    assign v_o     = sgn_mix[W-1];

endmodule

// File: rtl/acc_alu_shl.sv
module acc_alu_shl #(
    parameter int W = 8
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] res_o,
    output logic         c_o
);

    generate
        if (W >= 2) begin : g_wide
            assign res_o = {val_i[W-2:0], 1'b0};
        end else begin : g_narrow
            assign res_o = '0;
        end
    endgenerate

    assign c_o = val_i[W-1];

endmodule

// File: rtl/acc_alu_flagop.sv
module acc_alu_flagop
    import acc_alu_pkg::*;
(
    input  logic [2:0]        fn_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic [STAT_W-1:0] stat_o
);

    always_comb begin
        stat_o = stat_i;
        case (fn_i)
            3'd0: stat_o[BIT_C] = 1'b0;
            3'd1: stat_o[BIT_C] = 1'b1;
            3'd2: stat_o[BIT_I] = 1'b0;
            3'd3: stat_o[BIT_I] = 1'b1;
            3'd5: stat_o[BIT_V] = 1'b0;
            3'd6: stat_o[BIT_D] = 1'b0;
            3'd7: stat_o[BIT_D] = 1'b1;
            default: stat_o = stat_i;
        endcase
    end

endmodule

// File: rtl/acc_flag_alu.sv
module acc_flag_alu
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic [W-1:0]      operand_i,
    input  logic              apply_i,
    output logic [W-1:0]      acc_o,
    output logic [W-1:0]      mem_o,
    output logic [STAT_W-1:0] stat_o
);

    typedef struct packed {
        logic [W-1:0]      acc;
        logic [W-1:0]      mem;
        logic [STAT_W-1:0] stat;
    } regs_t;

    localparam regs_t RESET_VAL = '0;

    regs_t regs_d;
    regs_t regs_q;

    op_cls_e     cls;
    logic [2:0]  fn;

    logic [W-1:0]      ar_res;
    logic              ar_c;
    logic              ar_v;
    arith_ctl_t        ar_ctl;

    logic [W-1:0]      sh_src;
    logic [W-1:0]      sh_res;
    logic              sh_c;

    logic [STAT_W-1:0] fl_stat;

    acc_alu_decode u_decode (
        .op_i  (op_i),
        .cls_o (cls),
        .fn_o  (fn)
    );

    acc_alu_arith #(.W(W)) u_arith (
        .a_i   (regs_q.acc),
        .b_i   (operand_i),
        .c_i   (regs_q.stat[BIT_C]),
        .fn_i  (fn),
        .res_o (ar_res),
        .c_o   (ar_c),
        .v_o   (ar_v),
        .ctl_o (ar_ctl)
    );

    assign sh_src = (cls == CLS_SHL_ACC) ? regs_q.acc : operand_i;

    acc_alu_shl #(.W(W)) u_shl (
        .val_i (sh_src),
        .res_o (sh_res),
        .c_o   (sh_c)
    );

    acc_alu_flagop u_flagop (
        .fn_i   (fn),
        .stat_i (regs_q.stat),
        .stat_o (fl_stat)
    );

    always_comb begin
        regs_d = regs_q;
        if (apply_i) begin
            case (cls)
                CLS_ARITH: begin
                    if (ar_ctl.wr_acc) regs_d.acc = ar_res;
                    if (ar_ctl.upd_nz) begin
                        regs_d.stat[BIT_N] = ar_res[W-1];
                        regs_d.stat[BIT_Z] = (ar_res == '0);
                    end
                    if (ar_ctl.upd_c) regs_d.stat[BIT_C] = ar_c;
                    if (ar_ctl.upd_v) regs_d.stat[BIT_V] = ar_v;
                end
                CLS_FLAG: begin
                    regs_d.stat = fl_stat;
                end
                CLS_SHL_ACC: begin
                    regs_d.acc         = sh_res;
                    regs_d.stat[BIT_C] = sh_c;
                    regs_d.stat[BIT_N] = sh_res[W-1];
                    regs_d.stat[BIT_Z] = (sh_res == '0);
                end
                CLS_SHL_MEM: begin
                    regs_d.mem         = sh_res;
                    regs_d.stat[BIT_C] = sh_c;
                    regs_d.stat[BIT_N] = sh_res[W-1];
                    regs_d.stat[BIT_Z] = (sh_res == '0);
                end
                default: regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= RESET_VAL;
        else        regs_q <= regs_d;
    end

    assign acc_o  = regs_q.acc;
    assign mem_o  = regs_q.mem;
    assign stat_o = regs_q.stat;

endmodule

// File: rtl/acc_flag_alu_chk.sv
module acc_flag_alu_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [7:0]   op_i,
    input logic         apply_i,
    input logic [W-1:0] acc_o,
    input logic [W-1:0] mem_o,
    input logic [7:0]   stat_o
);

    logic is_grp1;
    logic is_cmp;
    logic is_logic;
    logic is_flagop;
    logic is_memshl;

    assign is_grp1   = apply_i && (op_i[1:0] == 2'b01);
    assign is_cmp    = is_grp1 && (op_i[7:5] == 3'd6);
    assign is_logic  = is_grp1 && (op_i[7:5] == 3'd0 || op_i[7:5] == 3'd1 ||
                                   op_i[7:5] == 3'd2 || op_i[7:5] == 3'd5);
    assign is_flagop = apply_i && (op_i[1:0] == 2'b00) && (op_i[4:2] == 3'b110);
    assign is_memshl = apply_i && (op_i[1:0] == 2'b10) && (op_i[7:5] == 3'd0) &&
                       (op_i[3:0] != 4'hA);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_i |=> ($stable(acc_o) && $stable(mem_o) && $stable(stat_o)));

    // R3
    logic_keeps_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_logic |=> (stat_o[0] == $past(stat_o[0]) && stat_o[6] == $past(stat_o[6])));

    // R3
    logic_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_logic |=> (stat_o[1] == (acc_o == '0) && stat_o[7] == acc_o[W-1]));

    // R6
    cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp |=> ($stable(acc_o) && stat_o[6] == $past(stat_o[6])));

    // R7
    flagop_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_flagop |=> ($stable(acc_o) && $stable(mem_o)));

    // R9
    memshl_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_memshl |=> $stable(acc_o));

    // R11
    fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(stat_o[5:4]));

    // R11
    id_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_flagop |=> $stable(stat_o[3:2]));

endmodule

bind acc_flag_alu acc_flag_alu_chk #(.W(W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .apply_i (apply_i),
    .acc_o   (acc_o),
    .mem_o   (mem_o),
    .stat_o  (stat_o)
);

// File: tb/acc_flag_alu_tb_top.sv
module acc_flag_alu_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 27;
    localparam int WATCHDOG   = 20000;

    // {req, op, operand, exp_acc, exp_stat, exp_mem}
    localparam logic [43:0] VEC [NVEC] = '{
        {4'd3,  8'h09, 8'h80, 8'h80, 8'h80, 8'h00}, // R3 OR
        {4'd3,  8'h29, 8'h7F, 8'h00, 8'h02, 8'h00}, // R3 AND to zero
        {4'd3,  8'hA9, 8'h7F, 8'h7F, 8'h00, 8'h00}, // R3 load
        {4'd7,  8'h38, 8'h00, 8'h7F, 8'h01, 8'h00}, // R7 set C
        {4'd4,  8'h69, 8'h01, 8'h81, 8'hC0, 8'h00}, // R4 add, V set
        {4'd4,  8'h69, 8'hFF, 8'h80, 8'h81, 8'h00}, // R4 add, carry out
        {4'd5,  8'hE9, 8'h01, 8'h7F, 8'h01, 8'h00}, // R5 subtract
        {4'd5,  8'hE9, 8'h80, 8'hFF, 8'h80, 8'h00}, // R5 subtract, borrow
        {4'd3,  8'hA9, 8'h7F, 8'h7F, 8'h00, 8'h00}, // R3 load keeps C,V
        {4'd5,  8'hE9, 8'h7F, 8'hFF, 8'hC0, 8'h00}, // R5 subtract, V set
        {4'd6,  8'hC9, 8'h0F, 8'hFF, 8'hC1, 8'h00}, // R6 compare keeps A and V
        {4'd7,  8'hB8, 8'h00, 8'hFF, 8'h81, 8'h00}, // R7 clear V
        {4'd7,  8'h78, 8'h00, 8'hFF, 8'h85, 8'h00}, // R7 set I
        {4'd7,  8'hF8, 8'h00, 8'hFF, 8'h8D, 8'h00}, // R7 set D
        {4'd8,  8'h0A, 8'h00, 8'hFE, 8'h8D, 8'h00}, // R8 shift A
        {4'd9,  8'h06, 8'h80, 8'hFE, 8'h0F, 8'h00}, // R9 shift memory to zero
        {4'd3,  8'h49, 8'h01, 8'hFF, 8'h8D, 8'h00}, // R3 XOR, R11 I/D kept
        {4'd10, 8'h85, 8'h12, 8'hFF, 8'h8D, 8'h00}, // R10 store slot
        {4'd7,  8'h98, 8'h00, 8'hFF, 8'h8D, 8'h00}, // R7 code 4 no effect
        {4'd10, 8'h4A, 8'h55, 8'hFF, 8'h8D, 8'h00}, // R10 other shift group
        {4'd7,  8'h18, 8'h00, 8'hFF, 8'h8C, 8'h00}, // R7 clear C
        {4'd7,  8'h58, 8'h00, 8'hFF, 8'h88, 8'h00}, // R7 clear I
        {4'd7,  8'hD8, 8'h00, 8'hFF, 8'h80, 8'h00}, // R7 clear D
        {4'd9,  8'h0E, 8'h41, 8'hFF, 8'h80, 8'h82}, // R9 shift memory
        {4'd8,  8'h0A, 8'h00, 8'hFE, 8'h81, 8'h82}, // R8 mem kept
        {4'd4,  8'h69, 8'h01, 8'h00, 8'h03, 8'h82}, // R4 wrap to zero
        {4'd6,  8'hC9, 8'h00, 8'h00, 8'h80, 8'h82}  // R6 equal operands, no carry-in
    };

    logic       clk;
    logic       rst_n;
    logic [7:0] op_i;
    logic [7:0] operand_i;
    logic       apply_i;
    logic [7:0] acc_o;
    logic [7:0] mem_o;
    logic [7:0] stat_o;

    int total;
    int bad;
    bit done;

    acc_flag_alu #(.W(8)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op_i),
        .operand_i (operand_i),
        .apply_i   (apply_i),
        .acc_o     (acc_o),
        .mem_o     (mem_o),
        .stat_o    (stat_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [7:0] ea,
                             input logic [7:0] es, input logic [7:0] em);
        check(req, "acc", acc_o, ea);
        check(req, "stat", stat_o, es);
        check(req, "mem", mem_o, em);
    endtask

    // drive at a falling edge; the result is visible at the next falling edge
    task automatic step(input logic [7:0] op, input logic [7:0] b, input logic ap);
        op_i      = op;
        operand_i = b;
        apply_i   = ap;
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        total     = 0;
        bad       = 0;
        done      = 1'b0;
        rst_n     = 1'b0;
        op_i      = 8'h00;
        operand_i = 8'h00;
        apply_i   = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R1", 8'h00, 8'h00, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", 8'h00, 8'h00, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][39:32], VEC[i][31:24], 1'b1);
            check_all($sformatf("R%0d", VEC[i][43:40]),
                      VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);
        end

        // R2: operations presented without the strobe have no effect
        step(8'h69, 8'h55, 1'b0);
        check_all("R2", 8'h00, 8'h80, 8'h82);
        step(8'h38, 8'h00, 1'b0);
        check_all("R2", 8'h00, 8'h80, 8'h82);
        step(8'h06, 8'hFF, 1'b0);
        check_all("R2", 8'h00, 8'h80, 8'h82);

        // R10: group 11 opcode ignored
        step(8'h6B, 8'h33, 1'b1);
        check_all("R10", 8'h00, 8'h80, 8'h82);

        // R11: fixed bits after a mix of operations
        check("R11", "stat[5:4]", {6'd0, stat_o[5:4]}, 8'h00);

        // R1: reset in the middle of activity
        op_i      = 8'h09;
        operand_i = 8'hFF;
        apply_i   = 1'b1;
        rst_n     = 1'b0;
        @(negedge clk);
        check_all("R1", 8'h00, 8'h00, 8'h00);
        apply_i = 1'b0;
        rst_n   = 1'b1;
        @(negedge clk);
        check_all("R1", 8'h00, 8'h00, 8'h00);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule